// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches 32 general-purpose input pins and turns selected pin conditions into interrupt requests. Each pin first passes through a two-flop synchronizer. A detector then tests the pin against its own trigger code, which can be low level, high level, rising edge or falling edge. A per-pin override bit makes the pin respond to either edge instead. Each detection latches a pending bit. Software clears a pending bit by writing a one to it.

A per-pin enable register gates the pending bits. Two registered request lines carry the result: one serves the lower half of the pins and the other serves the upper half. Software configures and services the block through a synchronous single-cycle register port. Writes take effect on the clock edge and reads return data combinationally from the offset. Registers are addressed by byte offset: pin data 0x08 (read-only), trigger low-half 0x0C, trigger high-half 0x10, enable 0x14, pending 0x18, any-edge 0x1C. Every other offset reads as zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable, any-edge and both trigger registers read 0, and both request outputs are 0.
- R2: The pin-data register (0x08) returns the pin inputs delayed by exactly two clock edges. After one edge it still shows the old value.
- R3: Trigger code 0 sets a pin's pending bit while the pin is low, and code 1 sets it while the pin is high. A pending bit that is cleared while the level persists is set again on the next edge.
- R4: Trigger code 2 sets the pending bit on a 0-to-1 pin transition only. A 1-to-0 transition leaves it clear.
- R5: Trigger code 3 sets the pending bit on a 1-to-0 pin transition only. A 0-to-1 transition leaves it clear.
- R6: Pin p < 16 takes its code from register 0x0C bits [2p+1:2p]. Pin p >= 16 takes its code from register 0x10 bits [2(p-16)+1:2(p-16)].
- R7: When bit p of the any-edge register (0x1C) is 1, both transitions of pin p set its pending bit, and its trigger code is ignored.
- R8: Writing to the pending register (0x18) clears each bit written as 1. Bits written as 0 are unchanged.
- R9: When a detection and a clearing write hit the same bit on the same edge, the bit stays set.
- R10: Pending bits are set whether or not the pin's enable bit is set.
- R11: Request output `irq_lo_o` is the OR of pending AND enable over pins 0 to 15. Request output `irq_hi_o` is the same over pins 16 to 31. Each output is registered, so it follows a change of pending or enable one edge later.
- R12: The enable, any-edge and trigger registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous pin inputs |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the offset |
| irq_lo_o | output | 1 | Request for pins 0 to 15 |
| irq_hi_o | output | 1 | Request for pins 16 to 31 |

## Verification
A pin change becomes visible in pin data after two edges and in the pending register after three edges. It reaches a request output after four edges. A register write changes state on the edge after the strobe, and a request output reacts to an enable or clear write one edge after that. The bench applies stimulus on the falling clock edge and waits a fixed number of falling edges for each of these paths before it samples. It also samples once one edge early to show that the registered stages are really present. Level-code checks sample immediately after a clear to catch a bit that is set again on the same edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_PIN_DATA = 8'h08;
  localparam logic [7:0] OFS_TRIG_LO  = 8'h0C;
  localparam logic [7:0] OFS_TRIG_HI  = 8'h10;
  localparam logic [7:0] OFS_ENABLE   = 8'h14;
  localparam logic [7:0] OFS_PENDING  = 8'h18;
  localparam logic [7:0] OFS_ANY_EDGE = 8'h1C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // Which trigger register holds the field of a pin.
  function automatic int trig_reg_of(input int pin, input int per_reg);
    return pin / per_reg;
  endfunction

  // Bit offset of the pin's field inside that register.
  function automatic int trig_bit_of(input int pin, input int per_reg);
    return 2 * (pin % per_reg);
  endfunction

  // Condition test for one pin from current and previous synchronized value.
  function automatic logic cond_met(input trig_e code, input logic any_edge,
                                    input logic cur, input logic prev);
    logic hit;
    if (any_edge) begin
      hit = cur ^ prev;
    end else begin
      unique case (code)
        TRIG_LOW:  hit = ~cur;
        TRIG_HIGH: hit = cur;
        TRIG_RISE: hit = cur & ~prev;
        default:   hit = ~cur & prev;
      endcase
    end
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  localparam int PER_REG = DATA_W / 2,
  localparam int NREGS   = (NUM_PINS + PER_REG - 1) / PER_REG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [DATA_W-1:0]   trig_i [NREGS],
  input  logic [NUM_PINS-1:0] any_edge_i,
  output logic [NUM_PINS-1:0] hit_o
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int RIDX = trig_reg_of(p, PER_REG);
    localparam int BOFS = trig_bit_of(p, PER_REG);
    trig_e code;
    assign code     = trig_e'(trig_i[RIDX][BOFS +: 2]);
    assign hit_o[p] = cond_met(code, any_edge_i[p], cur_i[p], prev_q[p]);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 32,
  parameter int GROUPS   = 2,
  localparam int GSIZE   = NUM_PINS / GROUPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] enable_i,
  output logic [NUM_PINS-1:0] pending_o,
  output logic [GROUPS-1:0]   req_o
);

  logic [NUM_PINS-1:0] pend_q;
  logic [GROUPS-1:0]   req_q;
  logic [NUM_PINS-1:0] gated;

  // Clear first, then set: a detection on the same edge wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | hit_i;
  end

  assign gated = pend_q & enable_i;

  for (genvar g = 0; g < GROUPS; g++) begin : g_req
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[g] <= 1'b0;
      else        req_q[g] <= |gated[g*GSIZE +: GSIZE];
    end
  end

  assign pending_o = pend_q;
  assign req_o     = req_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PER_REG    = DATA_W / 2,
  localparam int NREGS      = (NUM_PINS + PER_REG - 1) / PER_REG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                reg_wr_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_lo_o,
  output logic                irq_hi_o
);

  logic [NUM_PINS-1:0] sync_w;
  logic [NUM_PINS-1:0] hit_w;
  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] pending_w;
  logic [NUM_PINS-1:0] enable_q;
  logic [NUM_PINS-1:0] any_edge_q;
  logic [DATA_W-1:0]   trig_q [NREGS];
  logic [1:0]          req_w;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= '0;
      any_edge_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADDR_W'(OFS_ENABLE))   enable_q   <= reg_wdata_i[NUM_PINS-1:0];
      if (reg_addr_i == ADDR_W'(OFS_ANY_EDGE)) any_edge_q <= reg_wdata_i[NUM_PINS-1:0];
    end
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_trig
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(OFS_TRIG_LO) + ADDR_W'(4 * r);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               trig_q[r] <= '0;
      else if (reg_wr_i && reg_addr_i == OFS)   trig_q[r] <= reg_wdata_i;
    end
  end

  assign clr_w = (reg_wr_i && reg_addr_i == ADDR_W'(OFS_PENDING))
               ? reg_wdata_i[NUM_PINS-1:0] : '0;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_w)
  );

  gpio_irq_detect #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur_i(sync_w), .trig_i(trig_q),
    .any_edge_i(any_edge_q), .hit_o(hit_w)
  );

  gpio_irq_status #(.NUM_PINS(NUM_PINS), .GROUPS(2)) u_status (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_w), .clr_i(clr_w),
    .enable_i(enable_q), .pending_o(pending_w), .req_o(req_w)
  );

  assign irq_lo_o = req_w[0];
  assign irq_hi_o = req_w[1];

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(OFS_PIN_DATA)) reg_rdata_o = DATA_W'(sync_w);
    if (reg_addr_i == ADDR_W'(OFS_ENABLE))   reg_rdata_o = DATA_W'(enable_q);
    if (reg_addr_i == ADDR_W'(OFS_PENDING))  reg_rdata_o = DATA_W'(pending_w);
    if (reg_addr_i == ADDR_W'(OFS_ANY_EDGE)) reg_rdata_o = DATA_W'(any_edge_q);
    for (int r = 0; r < NREGS; r++) begin
      if (reg_addr_i == ADDR_W'(OFS_TRIG_LO) + ADDR_W'(4 * r)) reg_rdata_o = trig_q[r];
    end
  end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS = 32,
  localparam int HALF    = NUM_PINS / 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] hit_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] enable_vec,
  input logic                irq_lo,
  input logic                irq_hi
);

  // R9: every detection leaves its pending bit set on the next edge
  p_hit_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((pend_vec & $past(hit_vec)) == $past(hit_vec)));

  // R8: a pending bit only drops after a clearing write to that bit
  p_clear_only_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_vec) & ~pend_vec & ~$past(clr_vec)) == '0));

  // R3: a pending bit only rises after a detection
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0));

  // R11: low request follows gated pending of lower half one edge later
  p_irq_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_lo == |($past(pend_vec[HALF-1:0]) & $past(enable_vec[HALF-1:0]))));

  // R11: high request follows gated pending of upper half one edge later
  p_irq_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_hi == |($past(pend_vec[NUM_PINS-1:HALF]) & $past(enable_vec[NUM_PINS-1:HALF]))));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_w), .clr_vec(clr_w),
  .pend_vec(pending_w), .enable_vec(enable_q),
  .irq_lo(irq_lo_o), .irq_hi(irq_hi_o)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  localparam logic [7:0] A_PIN = 8'h08, A_TLO = 8'h0C, A_THI = 8'h10,
                         A_EN = 8'h14, A_PEND = 8'h18, A_ANY = 8'h1C;
  localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic baseline();
    wr_reg(A_TLO, ALL_RISE);
    wr_reg(A_THI, ALL_RISE);
    wr_reg(A_EN, '0);
    wr_reg(A_ANY, '0);
    pins = '0;
    wait_n(4);
    wr_reg(A_PEND, '1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(A_EN, v);  chk("R1 enable", v, 32'h0);
    rd_reg(A_ANY, v); chk("R1 any-edge", v, 32'h0);
    rd_reg(A_TLO, v); chk("R1 trig lo", v, 32'h0);
    rd_reg(A_THI, v); chk("R1 trig hi", v, 32'h0);
    chk("R1 irq outputs", {30'd0, irq_hi, irq_lo}, 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    pins = 32'hA5A5_0F0F;
    wait_n(1);
    rd_reg(A_PIN, v); chk("R2 one edge", v, 32'h0);
    wait_n(1);
    rd_reg(A_PIN, v); chk("R2 two edges", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_rising();
    logic [31:0] v;
    baseline();
    pins = 32'h0010_0008;
    wait_n(3);
    rd_reg(A_PEND, v); chk("R4 R6 rise pins 3,20", v, 32'h0010_0008);
    wr_reg(A_PEND, '1);
    pins = '0;
    wait_n(4);
    rd_reg(A_PEND, v); chk("R4 no set on fall", v, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    baseline();
    wr_reg(A_TLO, 32'hAAAA_AEAA);
    wr_reg(A_THI, 32'hAAAA_AEAA);
    pins = 32'h0020_0020;
    wait_n(4);
    rd_reg(A_PEND, v); chk("R5 no set on rise", v, 32'h0);
    pins = '0;
    wait_n(3);
    rd_reg(A_PEND, v); chk("R5 R6 fall pins 5,21", v, 32'h0020_0020);
  endtask

  task automatic t_level();
    logic [31:0] v;
    baseline();
    wr_reg(A_TLO, 32'hAAAA_6AAA);
    pins = 32'h0000_0080;
    wait_n(3);
    rd_reg(A_PEND, v); chk("R3 high level pin 7", v, 32'h0000_0080);
    wr_reg(A_PEND, 32'h0000_0080);
    rd_reg(A_PEND, v); chk("R3 R9 reset while high", v, 32'h0000_0080);
    pins = '0;
    wait_n(3);
    wr_reg(A_PEND, '1);
    rd_reg(A_PEND, v); chk("R3 stays clear after level ends", v, 32'h0);
    wr_reg(A_THI, 32'hAAAA_AAA8);
    wait_n(1);
    rd_reg(A_PEND, v); chk("R3 R6 low level pin 16", v, 32'h0001_0000);
    pins = 32'h0001_0000;
    wait_n(3);
    wr_reg(A_PEND, '1);
    rd_reg(A_PEND, v); chk("R3 low level released", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    baseline();
    pins = 32'h0010_0008;
    wait_n(3);
    wr_reg(A_PEND, 32'h0000_0008);
    rd_reg(A_PEND, v); chk("R8 write one clears", v, 32'h0010_0000);
    wr_reg(A_PEND, 32'h0);
    rd_reg(A_PEND, v); chk("R8 write zero keeps", v, 32'h0010_0000);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    baseline();
    pins = 32'h0010_0000;
    wait_n(4);
    rd_reg(A_PEND, v); chk("R10 set while disabled", v, 32'h0010_0000);
    chk("R10 no request while disabled", {31'd0, irq_hi}, 32'h0);
    wr_reg(A_EN, 32'h0010_0004);
    chk("R11 irq_hi not yet", {31'd0, irq_hi}, 32'h0);
    wait_n(1);
    chk("R11 irq_hi/lo after enable", {30'd0, irq_hi, irq_lo}, 32'h2);
    pins = 32'h0010_0004;
    wait_n(3);
    chk("R11 irq_lo one edge after pending", {31'd0, irq_lo}, 32'h0);
    wait_n(1);
    chk("R11 irq_lo set", {31'd0, irq_lo}, 32'h1);
    wr_reg(A_PEND, 32'h0010_0004);
    wait_n(1);
    chk("R11 both drop after clear", {30'd0, irq_hi, irq_lo}, 32'h0);
  endtask

  task automatic t_any_edge();
    logic [31:0] v;
    baseline();
    wr_reg(A_TLO, 32'hAAA6_AAAA);
    wr_reg(A_ANY, 32'h0000_0200);
    pins = 32'h0000_0200;
    wait_n(3);
    rd_reg(A_PEND, v); chk("R7 rise with any-edge", v, 32'h0000_0200);
    wr_reg(A_PEND, '1);
    wait_n(2);
    rd_reg(A_PEND, v); chk("R7 level code ignored", v, 32'h0);
    pins = '0;
    wait_n(3);
    rd_reg(A_PEND, v); chk("R7 fall with any-edge", v, 32'h0000_0200);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr_reg(A_EN, 32'h1234_5678);
    wr_reg(A_ANY, 32'h0F0F_00F0);
    wr_reg(A_THI, 32'h5555_0000);
    wr_reg(A_TLO, 32'h0000_FFFF);
    rd_reg(A_EN, v);  chk("R12 enable", v, 32'h1234_5678);
    rd_reg(A_ANY, v); chk("R12 any-edge", v, 32'h0F0F_00F0);
    rd_reg(A_THI, v); chk("R12 trig hi", v, 32'h5555_0000);
    rd_reg(A_TLO, v); chk("R12 trig lo", v, 32'h0000_FFFF);
    baseline();
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    t_sync();
    t_rising();
    t_falling();
    t_level();
    t_w1c();
    t_enable();
    t_any_edge();
    t_readback();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule